// File: doc/BRIEF.md
# Serial Boot Mode and Bit-Rate Detector

This block sits at the front of a serial boot loader. After reset it watches a raw receive pin. It learns two things from the single signature byte a host sends first. The first is the protocol: asynchronous start/stop framing, or a clocked synchronous link in which the host drives a serial clock. The second is the host's bit period, counted in system clocks. The signature always arrives on the pin as an asynchronous frame sent least significant bit first. In the synchronous case it is sent at one sixteenth of the working rate, so the block divides the measured period by sixteen before it programs the divider.

Once the mode is settled, the block sends the signature back as an acknowledge. It then delivers every later byte to a command layer as a one-cycle valid pulse. In asynchronous mode the block samples bits with its own divider and flags a bad stop bit. In synchronous mode it shifts bits in on the host's clock and performs no error checking. Three conditions send the block into a latched abort that only reset clears: a signature that is neither value, a measurement that runs past its time limit, or an asynchronous bit period the divider cannot produce.

Top module: `boot_serial_detect`

## Requirements
- R1: After reset, tx_o is 1, byte_valid_o, frame_err_o, abort_o and mode_sync_o are 0, and rate_div_o is 0.
- R2: A first byte of 86H selects asynchronous mode (mode_sync_o = 0). rate_div_o is set to the bit period in clocks, taken as half the length of the 2-bit high run that follows the first rising edge.
- R3: In asynchronous mode the acknowledge is 86H, sent on tx_o as one start bit (0), eight data bits LSB first and one stop bit (1), each lasting rate_div_o clocks.
- R4: No byte_valid_o pulse is produced for the signature byte or during the acknowledge, because the data receivers stay disabled until the acknowledge completes.
- R5: In asynchronous mode, a measured bit period below MIN_DIV or above MAX_DIV sends the block to abort. While abort_o is 1, tx_o is 1.
- R6: A first byte of 30H selects synchronous mode (mode_sync_o = 1). rate_div_o is set to the measured bit period divided by 16.
- R7: In synchronous mode the acknowledge 30H is shifted out on tx_o LSB first. Bit 0 is present when the acknowledge starts, and each falling edge of sclk_i advances tx_o by one bit. The acknowledge ends after the eighth falling edge.
- R8: In synchronous mode, later bytes are sampled from rx_i on rising edges of sclk_i, LSB first. After eight edges the byte is presented with a one-cycle byte_valid_o pulse, and frame_err_o never rises.
- R9: In asynchronous mode, later frames are sampled at mid-bit using rate_div_o. byte_valid_o pulses at the stop bit, and frame_err_o pulses with it when the stop bit is 0.
- R10: A first byte that is neither 86H nor 30H (for example CCH) sends the block to abort.
- R11: If rx_i stays low for TIMEOUT_CYC clocks while the first byte is being measured, the block aborts.
- R12: Abort is latched until reset. Further traffic on rx_i produces no byte_valid_o, and abort_o and tx_o stay at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| rx_i | input | 1 | Raw serial receive pin |
| sclk_i | input | 1 | External serial clock (synchronous mode) |
| tx_o | output | 1 | Serial transmit pin, idles high |
| byte_o | output | 8 | Received data byte |
| byte_valid_o | output | 1 | One-cycle pulse qualifying byte_o |
| frame_err_o | output | 1 | Stop bit was 0 (asynchronous mode only) |
| abort_o | output | 1 | Latched abort |
| mode_sync_o | output | 1 | 1 = synchronous mode selected |
| rate_div_o | output | $clog2(MAX_DIV+1) | Programmed bit period in clocks |

## Verification
The bench builds the block with MIN_DIV = 4 and MAX_DIV = 64, and leaves TIMEOUT_CYC at its default of 8192. A 16-clock asynchronous bit gives a divider in the middle of the legal range. Periods of 3 and 80 clocks fall on each side of the limits and exercise the rate abort. A 64-clock signature lands on a synchronous divider of exactly 4. With this small MAX_DIV, a stuck-low pin reaches the time limit in about eight thousand clocks.

// File: rtl/bsd_pkg.sv
package bsd_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_MEASURE, ST_DECIDE, ST_ECHO, ST_RUN, ST_ABORT
  } bsd_state_e;

  localparam logic [7:0] SIG_ASYNC = 8'h86;
  localparam logic [7:0] SIG_SYNC  = 8'h30;
endpackage

// File: rtl/bsd_sync2.sv
module bsd_sync2 #(
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic meta_q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      meta_q <= RST_VAL;
      q_o    <= RST_VAL;
    end else begin
      meta_q <= d_i;
      q_o    <= meta_q;
    end
endmodule

// File: rtl/bsd_tx.sv
module bsd_tx #(
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          sync_i,
  input  logic [7:0]    data_i,
  input  logic [DW-1:0] div_i,
  input  logic          sclk_fall_i,
  output logic          tx_o,
  output logic          done_o
);
  logic          busy_q;
  logic [9:0]    sh_q;
  logic [3:0]    bit_q;
  logic [DW-1:0] tick_q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      busy_q <= 1'b0;
      sh_q   <= '1;
      bit_q  <= '0;
      tick_q <= '0;
      done_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (!busy_q) begin
        if (start_i) begin
          busy_q <= 1'b1;
          bit_q  <= '0;
          tick_q <= '0;
          sh_q   <= sync_i ? {2'b11, data_i} : {1'b1, data_i, 1'b0};
        end
      end else if (sync_i) begin
        // host clock paces the shift
        if (sclk_fall_i) begin
          sh_q  <= {1'b1, sh_q[9:1]};
          bit_q <= bit_q + 4'd1;
          if (bit_q == 4'd7) begin
            busy_q <= 1'b0;
            done_o <= 1'b1;
          end
        end
      end else if (tick_q == div_i - 1'b1) begin
        tick_q <= '0;
        sh_q   <= {1'b1, sh_q[9:1]};
        bit_q  <= bit_q + 4'd1;
        if (bit_q == 4'd9) begin
          busy_q <= 1'b0;
          done_o <= 1'b1;
        end
      end else begin
        tick_q <= tick_q + 1'b1;
      end
    end

  assign tx_o = busy_q ? sh_q[0] : 1'b1;

  assert_sync_tx_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && sync_i && !sclk_fall_i) |=> $stable(tx_o));
endmodule

// File: rtl/bsd_uart_rx.sv
module bsd_uart_rx #(
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          rx_i,
  input  logic          fall_i,
  input  logic [DW-1:0] div_i,
  output logic [7:0]    data_o,
  output logic          valid_o,
  output logic          ferr_o
);
  logic          act_q;
  logic [3:0]    bit_q;
  logic [DW-1:0] tick_q;
  logic [DW-1:0] lim;

  // first wait is half a bit to land mid-start
  assign lim = (bit_q == 4'd0) ? (div_i >> 1) : div_i;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      act_q   <= 1'b0;
      bit_q   <= '0;
      tick_q  <= '0;
      data_o  <= '0;
      valid_o <= 1'b0;
      ferr_o  <= 1'b0;
    end else begin
      valid_o <= 1'b0;
      ferr_o  <= 1'b0;
      if (!en_i) begin
        act_q <= 1'b0;
      end else if (!act_q) begin
        if (fall_i) begin
          act_q  <= 1'b1;
          bit_q  <= '0;
          tick_q <= '0;
        end
      end else if (tick_q == lim - 1'b1) begin
        tick_q <= '0;
        bit_q  <= bit_q + 4'd1;
        if (bit_q == 4'd0) begin
          if (rx_i) act_q <= 1'b0;
        end else if (bit_q == 4'd9) begin
          valid_o <= 1'b1;
          ferr_o  <= ~rx_i;
          act_q   <= 1'b0;
        end else begin
          data_o <= {rx_i, data_o[7:1]};
        end
      end else begin
        tick_q <= tick_q + 1'b1;
      end
    end

  assert_ferr_with_valid_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ferr_o |-> valid_o);
endmodule

// File: rtl/bsd_sync_rx.sv
module bsd_sync_rx (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       en_i,
  input  logic       rx_i,
  input  logic       sclk_rise_i,
  output logic [7:0] data_o,
  output logic       valid_o
);
  logic [2:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      cnt_q   <= '0;
      data_o  <= '0;
      valid_o <= 1'b0;
    end else begin
      valid_o <= 1'b0;
      if (!en_i) begin
        cnt_q <= '0;
      end else if (sclk_rise_i) begin
        data_o <= {rx_i, data_o[7:1]};
        cnt_q  <= cnt_q + 3'd1;
        if (cnt_q == 3'd7) valid_o <= 1'b1;
      end
    end
endmodule

// File: rtl/boot_serial_detect.sv
module boot_serial_detect #(
  parameter int MIN_DIV     = 4,
  parameter int MAX_DIV     = 255,
  parameter int TIMEOUT_CYC = 8 * 16 * MAX_DIV,
  localparam int DW = $clog2(MAX_DIV + 1),
  localparam int CW = $clog2(TIMEOUT_CYC + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          rx_i,
  input  logic          sclk_i,
  output logic          tx_o,
  output logic [7:0]    byte_o,
  output logic          byte_valid_o,
  output logic          frame_err_o,
  output logic          abort_o,
  output logic          mode_sync_o,
  output logic [DW-1:0] rate_div_o
);
  import bsd_pkg::*;

  localparam logic [CW-1:0] TMO = CW'(TIMEOUT_CYC - 1);

  logic rx_s, rx_q, sclk_s, sclk_q;
  logic rx_fall, rx_rise, sclk_rise, sclk_fall;

  bsd_sync2 #(.RST_VAL(1'b1)) u_sync_rx (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(rx_i), .q_o(rx_s));
  bsd_sync2 #(.RST_VAL(1'b0)) u_sync_sclk (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(sclk_i), .q_o(sclk_s));

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      rx_q   <= 1'b1;
      sclk_q <= 1'b0;
    end else begin
      rx_q   <= rx_s;
      sclk_q <= sclk_s;
    end

  assign rx_fall   = rx_q & ~rx_s;
  assign rx_rise   = ~rx_q & rx_s;
  assign sclk_rise = ~sclk_q & sclk_s;
  assign sclk_fall = sclk_q & ~sclk_s;

  bsd_state_e    state_q;
  logic [CW-1:0] cnt_q, low_q, high_q;
  logic          hi_ph_q, seen_rise_q, mode_sync_q, tx_go_q;
  logic [DW-1:0] div_q;

  // classification: high run is 2 bits for both signatures,
  // low run is 2 bits (async) or 5 bits (sync)
  logic [CW+1:0] lw, hw;
  logic [CW-1:0] meas, sdiv;
  logic          is_async, is_sync, async_ok, drain_done;
  logic [DW-1:0] new_div;

  assign lw         = {2'b00, low_q};
  assign hw         = {2'b00, high_q};
  assign is_async   = ((lw << 1) < (hw + (hw << 1))) && ((lw << 1) > hw);
  assign is_sync    = (lw > (hw << 1)) && (lw < (hw + (hw << 1)));
  assign meas       = high_q >> 1;
  assign sdiv       = meas >> 4;
  assign async_ok   = (meas >= CW'(MIN_DIV)) && (meas <= CW'(MAX_DIV));
  assign drain_done = seen_rise_q && ({1'b0, cnt_q} >= {meas, 1'b0});
  assign new_div    = is_sync ? ((sdiv > CW'(MAX_DIV)) ? DW'(MAX_DIV) : sdiv[DW-1:0])
                              : meas[DW-1:0];

  logic tx_done;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      cnt_q       <= '0;
      low_q       <= '0;
      high_q      <= '0;
      hi_ph_q     <= 1'b0;
      seen_rise_q <= 1'b0;
      mode_sync_q <= 1'b0;
      div_q       <= '0;
      tx_go_q     <= 1'b0;
    end else begin
      tx_go_q <= 1'b0;
      case (state_q)
        ST_IDLE: if (rx_fall) begin
          state_q <= ST_MEASURE;
          cnt_q   <= '0;
          hi_ph_q <= 1'b0;
        end
        ST_MEASURE: begin
          if (cnt_q == TMO) begin
            state_q <= ST_ABORT;
          end else if (!hi_ph_q && rx_rise) begin
            low_q   <= cnt_q + 1'b1;
            cnt_q   <= '0;
            hi_ph_q <= 1'b1;
          end else if (hi_ph_q && rx_fall) begin
            high_q      <= cnt_q + 1'b1;
            cnt_q       <= '0;
            seen_rise_q <= 1'b0;
            state_q     <= ST_DECIDE;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        ST_DECIDE: begin
          if ((!is_async && !is_sync) || (is_async && !async_ok) || cnt_q == TMO) begin
            state_q <= ST_ABORT;
          end else if (rx_rise) begin
            seen_rise_q <= 1'b1;
            cnt_q       <= '0;
          end else if (drain_done) begin
            // rest of signature has cleared the line
            state_q     <= ST_ECHO;
            mode_sync_q <= is_sync;
            div_q       <= new_div;
            tx_go_q     <= 1'b1;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        ST_ECHO: if (tx_done) state_q <= ST_RUN;
        default: ;
      endcase
    end

  logic tx_line;

  bsd_tx #(.DW(DW)) u_tx (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(tx_go_q), .sync_i(mode_sync_q),
    .data_i(mode_sync_q ? SIG_SYNC : SIG_ASYNC), .div_i(div_q),
    .sclk_fall_i(sclk_fall), .tx_o(tx_line), .done_o(tx_done));

  logic       run, urx_valid, urx_ferr, srx_valid;
  logic [7:0] urx_data, srx_data;

  assign run = (state_q == ST_RUN);

  bsd_uart_rx #(.DW(DW)) u_urx (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(run && !mode_sync_q), .rx_i(rx_s),
    .fall_i(rx_fall), .div_i(div_q), .data_o(urx_data), .valid_o(urx_valid),
    .ferr_o(urx_ferr));

  bsd_sync_rx u_srx (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(run && mode_sync_q), .rx_i(rx_s),
    .sclk_rise_i(sclk_rise), .data_o(srx_data), .valid_o(srx_valid));

  assign tx_o         = (state_q == ST_ABORT) ? 1'b1 : tx_line;
  assign byte_o       = mode_sync_q ? srx_data : urx_data;
  assign byte_valid_o = run && (mode_sync_q ? srx_valid : urx_valid);
  assign frame_err_o  = run && !mode_sync_q && urx_ferr;
  assign abort_o      = (state_q == ST_ABORT);
  assign mode_sync_o  = mode_sync_q;
  assign rate_div_o   = div_q;

  assert_abort_sticky_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_o |=> abort_o);
  assert_abort_quiet_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_o |-> (tx_o && !byte_valid_o));
  assert_rx_off_before_run_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run |-> (!urx_valid && !srx_valid));
  assert_async_div_range_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run && !mode_sync_q) |-> (rate_div_o >= DW'(MIN_DIV) && rate_div_o <= DW'(MAX_DIV)));
  assert_no_ferr_sync_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_sync_o |-> !frame_err_o);
  assert_valid_pulse_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_valid_o |=> !byte_valid_o);
endmodule

// File: tb/boot_serial_detect_tb.sv
module boot_serial_detect_tb;
  localparam int MIN_DIV = 4;
  localparam int MAX_DIV = 64;
  localparam int DW = $clog2(MAX_DIV + 1);

  logic clk = 1'b0, rst_n = 1'b0, rx = 1'b1, sclk = 1'b0;
  logic tx, byte_valid, frame_err, abort_f, mode_sync;
  logic [7:0] byte_d;
  logic [DW-1:0] rate_div;

  int n_checks = 0, n_fail = 0;
  int n_bytes = 0;
  logic [7:0] last_byte;
  logic last_ferr;

  always #2 clk = ~clk;

  boot_serial_detect #(.MIN_DIV(MIN_DIV), .MAX_DIV(MAX_DIV)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .rx_i(rx), .sclk_i(sclk), .tx_o(tx),
    .byte_o(byte_d), .byte_valid_o(byte_valid), .frame_err_o(frame_err),
    .abort_o(abort_f), .mode_sync_o(mode_sync), .rate_div_o(rate_div));

  always @(negedge clk)
    if (rst_n && byte_valid) begin
      n_bytes++;
      last_byte = byte_d;
      last_ferr = frame_err;
    end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; rx = 1'b1; sclk = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    n_bytes = 0;
    repeat (2) @(negedge clk);
  endtask

  task automatic send_async(input logic [7:0] b, input int p, input bit stop);
    rx = 1'b0; repeat (p) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      rx = b[i]; repeat (p) @(negedge clk);
    end
    rx = stop; repeat (p) @(negedge clk);
    rx = 1'b1;
  endtask

  task automatic expect_async_echo(input logic [7:0] exp, input int p, input string req);
    logic [7:0] got = '0;
    int wait_c = 0;
    while (tx && wait_c < 2000) begin @(negedge clk); wait_c++; end
    chk(!tx, {req, " start bit"}, tx, 0);
    repeat (p / 2) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      repeat (p) @(negedge clk);
      got[i] = tx;
    end
    repeat (p) @(negedge clk);
    chk(got == exp, {req, " echo byte"}, got, exp);
    chk(tx == 1'b1, {req, " stop bit"}, tx, 1);
    repeat (p) @(negedge clk);
  endtask

  task automatic sync_byte(input logic [7:0] b);
    for (int i = 0; i < 8; i++) begin
      rx = b[i]; repeat (4) @(negedge clk);
      sclk = 1'b1; repeat (8) @(negedge clk);
      sclk = 1'b0; repeat (8) @(negedge clk);
    end
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset();
    do_reset();
    chk(tx == 1'b1, "R1 tx idle", tx, 1);
    chk(!byte_valid && !frame_err, "R1 valid/ferr low", {byte_valid, frame_err}, 0);
    chk(!abort_f && !mode_sync, "R1 abort/mode low", {abort_f, mode_sync}, 0);
    chk(rate_div == '0, "R1 divider zero", rate_div, 0);
  endtask

  task automatic t_async();
    do_reset();
    send_async(8'h86, 16, 1'b1);
    expect_async_echo(8'h86, 16, "R3");
    chk(!mode_sync && !abort_f, "R2 async mode", {mode_sync, abort_f}, 0);
    chk(rate_div == 16, "R2 divider", rate_div, 16);
    chk(n_bytes == 0, "R4 no byte for signature", n_bytes, 0);
    send_async(8'h5A, 16, 1'b1);
    repeat (40) @(negedge clk);
    chk(n_bytes == 1 && last_byte == 8'h5A, "R9 async byte", last_byte, 8'h5A);
    chk(last_ferr == 1'b0, "R9 good stop", last_ferr, 0);
    send_async(8'hC3, 16, 1'b0);
    repeat (40) @(negedge clk);
    chk(n_bytes == 2 && last_byte == 8'hC3, "R9 second byte", last_byte, 8'hC3);
    chk(last_ferr == 1'b1, "R9 framing error", last_ferr, 1);
  endtask

  task automatic t_sync();
    do_reset();
    send_async(8'h30, 64, 1'b1);
    repeat (200) @(negedge clk);
    chk(mode_sync == 1'b1 && !abort_f, "R6 sync mode", mode_sync, 1);
    chk(rate_div == 4, "R6 divider /16", rate_div, 4);
    for (int i = 0; i < 8; i++) begin
      chk(tx == SIG_BIT(i), "R7 echo bit", tx, SIG_BIT(i));
      sclk = 1'b1; repeat (16) @(negedge clk);
      sclk = 1'b0; repeat (16) @(negedge clk);
    end
    chk(n_bytes == 0, "R4 no byte during echo", n_bytes, 0);
    sync_byte(8'hA5);
    chk(n_bytes == 1 && last_byte == 8'hA5, "R8 sync byte", last_byte, 8'hA5);
    chk(last_ferr == 1'b0, "R8 no ferr", last_ferr, 0);
    sync_byte(8'h3C);
    chk(n_bytes == 2 && last_byte == 8'h3C, "R8 second sync byte", last_byte, 8'h3C);
  endtask

  function automatic logic SIG_BIT(input int i);
    logic [7:0] s = 8'h30;
    return s[i];
  endfunction

  task automatic t_bad_rate();
    do_reset();
    send_async(8'h86, 80, 1'b1);
    repeat (40) @(negedge clk);
    chk(abort_f == 1'b1, "R5 too slow aborts", abort_f, 1);
    chk(tx == 1'b1, "R5 tx idle in abort", tx, 1);
    do_reset();
    send_async(8'h86, 3, 1'b1);
    repeat (40) @(negedge clk);
    chk(abort_f == 1'b1, "R5 too fast aborts", abort_f, 1);
  endtask

  task automatic t_bad_sig();
    do_reset();
    send_async(8'hCC, 16, 1'b1);
    repeat (40) @(negedge clk);
    chk(abort_f == 1'b1, "R10 bad signature", abort_f, 1);
    send_async(8'h86, 16, 1'b1);
    send_async(8'h55, 16, 1'b1);
    repeat (200) @(negedge clk);
    chk(n_bytes == 0, "R12 no bytes after abort", n_bytes, 0);
    chk(abort_f == 1'b1, "R12 abort latched", abort_f, 1);
    chk(tx == 1'b1, "R12 tx stays high", tx, 1);
  endtask

  task automatic t_timeout();
    do_reset();
    rx = 1'b0;
    repeat (8300) @(negedge clk);
    chk(abort_f == 1'b1, "R11 timeout aborts", abort_f, 1);
    rx = 1'b1;
    repeat (20) @(negedge clk);
  endtask

  initial begin
    t_reset();
    t_async();
    t_sync();
    t_bad_rate();
    t_bad_sig();
    t_timeout();
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule